// File: doc/BRIEF.md
# PCI Type 0 Configuration Header

This block is the configuration register file of a 32-bit PCI target. It covers dword indices 0 to 15, which are the first 64 bytes of a Type 0 header. Configuration software reaches it through a simple dword port. A request carries a 6-bit register number, a write flag, four byte enables and write data. A read returns its data one clock later. Identity values are fixed at build time: vendor, device, subsystem, revision, class, interrupt pin and capabilities pointer. Command, status, latency timer, interrupt line and up to three base address registers can be changed by software.

Each base address register is set at build time. The build settings say whether the register is present, whether it maps memory or I/O space, and the log2 of its window size, from 4 (16 bytes) to 31 (2 GB). The block also decodes an incoming bus address against the programmed windows. It raises one hit line per register when that register's address space is enabled in the Command register.

Top module: `cfgspace_top`

## Requirements
- R1: Index 0 reads {device id, vendor id}. Index 2 reads {class code[23:0], revision[7:0]}. Index 11 reads {subsystem id, subsystem vendor id}. With defaults these are 32'h3C4D1A2B, 32'h11800002 and 32'h5E6F7A8B. Header type and BIST read zero.
- R2: Indices 7 to 10, 12, 14 and 16 to 63 always read 32'h0. These cover the unused base registers, the card information pointer, the ROM base and everything past the header.
- R3: A read request accepted at a clock edge shows cfgRdValid high for exactly the following cycle, with its data on cfgRdData. cfgRdData is zero whenever cfgRdValid is low.
- R4: Base register bits below the window size read zero. Bit 0 reads 1 for an I/O register and 0 for a memory register. Writing all ones to a base register returns the size mask. With defaults, index 4 (4 KB memory) returns 32'hFFFFF000, index 5 (32-byte I/O) returns 32'hFFFFFFE1 and index 6 (2 GB memory) returns 32'h80000000.
- R5: A write changes only the bytes whose enable bit is set. cfgByteEn[n] covers data bits 8n+7 down to 8n.
- R6: Writes to indices 0, 2, 11 and 13 leave them unchanged.
- R7: The Command register is bits 15:0 of index 1. Only bits 0 (I/O space enable), 1 (memory space enable), 2, 6 and 8 are writable. All other bits read zero.
- R8: Status bit 15 (index 1 bit 31) is set by a parityErrEvt pulse. Status bit 11 (index 1 bit 27) is set by a targetAbortEvt pulse. Each bit is cleared by writing 1 to it with byte enable 3 set. If a set and a clear hit the same cycle, the set wins.
- R9: Reset clears Command, both Status error bits, latency timer, interrupt line and all base bits.
- R10: barHit[i] is high only when all of the following hold:
  - busAddrValid is high;
  - busIsIo matches the register's type;
  - the matching Command enable bit is set (bit 0 for I/O, bit 1 for memory);
  - busAddr equals the base on every bit at or above the window size.
- R11: Index 13 reads the capabilities pointer in bits 7:0, 8'h40 by default, and zero above.
- R12: Index 3 bits 15:8 hold the writable latency timer. Index 15 bits 7:0 hold the writable interrupt line and bits 15:8 the fixed interrupt pin (8'h01 by default). All other bits of these two indices read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgValid | input | 1 | Configuration access request |
| cfgWrite | input | 1 | 1 = write, 0 = read |
| cfgRegNum | input | 6 | Dword register index |
| cfgByteEn | input | 4 | Per-byte write enables |
| cfgWrData | input | 32 | Write data |
| cfgRdData | output | 32 | Read data, one cycle after the request |
| cfgRdValid | output | 1 | Read data valid |
| parityErrEvt | input | 1 | Sets the parity-error status bit |
| targetAbortEvt | input | 1 | Sets the target-abort status bit |
| busAddr | input | 32 | Address to decode |
| busAddrValid | input | 1 | Address qualifier |
| busIsIo | input | 1 | 1 = I/O space address, 0 = memory |
| barHit | output | 3 | Per-base-register decode hit |

## Verification
Reads sweep every index, so the implemented registers are told apart from the zero-reading ones. All-ones writes to the I/O and memory base registers, including the 2 GB one, expose the size masks and the type bits. Partial byte-enable writes show whether the enables are honoured byte by byte, rather than applied to the whole word or ignored. Address probes test each hit condition in isolation: just inside and just outside a window, the wrong space type, and a disabled space enable bit. A set-and-clear collision on a status bit settles which of the two takes priority.

// File: rtl/cfgspace_pkg.sv
package cfgspace_pkg;
  localparam int NUM_BARS = 3;

  localparam logic [5:0] IDX_ID      = 6'd0;
  localparam logic [5:0] IDX_CMDSTAT = 6'd1;
  localparam logic [5:0] IDX_CLASS   = 6'd2;
  localparam logic [5:0] IDX_MISC    = 6'd3;
  localparam logic [5:0] IDX_BAR0    = 6'd4;
  localparam logic [5:0] IDX_SUBSYS  = 6'd11;
  localparam logic [5:0] IDX_CAP     = 6'd13;
  localparam logic [5:0] IDX_INTR    = 6'd15;

  localparam logic [7:0] CMD_LO_WMASK = 8'h47;
  localparam logic [7:0] CMD_HI_WMASK = 8'h01;

  typedef struct packed {
    logic                rdEn;
    logic                wrCmdStat;
    logic                wrLat;
    logic                wrIntLine;
    logic [NUM_BARS-1:0] wrBar;
  } cfgStrobe_t;

  function automatic logic [31:0] barMask(input int unsigned sizeLog2);
    return ~((32'd1 << sizeLog2) - 32'd1);
  endfunction

  function automatic logic [31:0] mergeBytes(input logic [31:0] oldVal,
                                             input logic [31:0] newVal,
                                             input logic [3:0]  be);
    logic [31:0] res;
    res = oldVal;
    for (int b = 0; b < 4; b++)
      if (be[b]) res[8*b +: 8] = newVal[8*b +: 8];
    return res;
  endfunction
endpackage

// File: rtl/cfgspace_ctrl.sv
module cfgspace_ctrl
  import cfgspace_pkg::*;
#(
  parameter logic [NUM_BARS-1:0]   BAR_USED  = 3'b111,
  parameter logic [NUM_BARS-1:0]   BAR_IS_IO = 3'b010,
  parameter logic [5*NUM_BARS-1:0] BAR_LOG2  = {5'd31, 5'd5, 5'd12}
) (
  input  logic                     cfgValid,
  input  logic                     cfgWrite,
  input  logic [5:0]               cfgRegNum,
  input  logic [3:0]               cfgByteEn,
  input  logic [31:0]              busAddr,
  input  logic                     busAddrValid,
  input  logic                     busIsIo,
  input  logic [1:0]               spaceEn,
  input  logic [NUM_BARS*32-1:0]   barBases,
  output cfgStrobe_t               strobe,
  output logic [NUM_BARS-1:0]      barHit
);
  logic                wrAcc;
  logic [NUM_BARS-1:0] barWr;

  assign wrAcc = cfgValid & cfgWrite;

  for (genvar i = 0; i < NUM_BARS; i++) begin : g_bar
    localparam logic [31:0] MASK = barMask(BAR_LOG2[5*i +: 5]);
    logic spaceOk;
    assign spaceOk  = BAR_IS_IO[i] ? spaceEn[0] : spaceEn[1];
    assign barWr[i] = BAR_USED[i] && wrAcc && (cfgRegNum == IDX_BAR0 + 6'(i));
    assign barHit[i] = BAR_USED[i] && busAddrValid && (busIsIo == BAR_IS_IO[i])
                       && spaceOk
                       && ((busAddr & MASK) == (barBases[32*i +: 32] & MASK));
  end

  always_comb begin
    strobe.rdEn      = cfgValid & ~cfgWrite;
    strobe.wrCmdStat = wrAcc && (cfgRegNum == IDX_CMDSTAT);
    strobe.wrLat     = wrAcc && (cfgRegNum == IDX_MISC) && cfgByteEn[1];
    strobe.wrIntLine = wrAcc && (cfgRegNum == IDX_INTR) && cfgByteEn[0];
    strobe.wrBar     = barWr;
  end
endmodule

// File: rtl/cfgspace_datapath.sv
module cfgspace_datapath
  import cfgspace_pkg::*;
#(
  parameter logic [15:0]           VENDOR_ID  = 16'h1A2B,
  parameter logic [15:0]           DEVICE_ID  = 16'h3C4D,
  parameter logic [7:0]            REVISION   = 8'h02,
  parameter logic [23:0]           CLASS_CODE = 24'h118000,
  parameter logic [15:0]           SUB_VEN_ID = 16'h7A8B,
  parameter logic [15:0]           SUB_ID     = 16'h5E6F,
  parameter logic [7:0]            CAP_PTR    = 8'h40,
  parameter logic [7:0]            INT_PIN    = 8'h01,
  parameter logic [NUM_BARS-1:0]   BAR_USED   = 3'b111,
  parameter logic [NUM_BARS-1:0]   BAR_IS_IO  = 3'b010,
  parameter logic [5*NUM_BARS-1:0] BAR_LOG2   = {5'd31, 5'd5, 5'd12}
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  cfgStrobe_t             strobe,
  input  logic [5:0]             cfgRegNum,
  input  logic [3:0]             cfgByteEn,
  input  logic [31:0]            cfgWrData,
  input  logic                   parityErrEvt,
  input  logic                   targetAbortEvt,
  output logic [1:0]             spaceEn,
  output logic [NUM_BARS*32-1:0] barBases,
  output logic [31:0]            cfgRdData,
  output logic                   cfgRdValid
);
  logic [15:0] cmdReg;
  logic        statPerr;
  logic        statTabort;
  logic [7:0]  latTimer;
  logic [7:0]  intLine;
  logic [31:0] barRead [NUM_BARS];
  logic [31:0] rdMux;
  logic [15:0] statusWord;

  for (genvar i = 0; i < NUM_BARS; i++) begin : g_bar
    localparam logic [31:0] MASK    = barMask(BAR_LOG2[5*i +: 5]);
    localparam logic [31:0] TYPEBIT = BAR_IS_IO[i] ? 32'h1 : 32'h0;
    logic [31:0] base;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)              base <= '0;
      else if (strobe.wrBar[i]) base <= mergeBytes(base, cfgWrData, cfgByteEn) & MASK;
    end
    assign barBases[32*i +: 32] = base;
    assign barRead[i] = BAR_USED[i] ? (base | TYPEBIT) : 32'h0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmdReg     <= '0;
      statPerr   <= 1'b0;
      statTabort <= 1'b0;
      latTimer   <= '0;
      intLine    <= '0;
    end else begin
      if (strobe.wrCmdStat && cfgByteEn[0]) cmdReg[7:0]  <= cfgWrData[7:0] & CMD_LO_WMASK;
      if (strobe.wrCmdStat && cfgByteEn[1]) cmdReg[15:8] <= cfgWrData[15:8] & CMD_HI_WMASK;
      statPerr   <= (statPerr & ~(strobe.wrCmdStat & cfgByteEn[3] & cfgWrData[31]))
                    | parityErrEvt;
      statTabort <= (statTabort & ~(strobe.wrCmdStat & cfgByteEn[3] & cfgWrData[27]))
                    | targetAbortEvt;
      if (strobe.wrLat)     latTimer <= cfgWrData[15:8];
      if (strobe.wrIntLine) intLine  <= cfgWrData[7:0];
    end
  end

  assign statusWord = {statPerr, 3'b000, statTabort, 11'd0};
  assign spaceEn    = cmdReg[1:0];

  always_comb begin
    case (cfgRegNum)
      IDX_ID:       rdMux = {DEVICE_ID, VENDOR_ID};
      IDX_CMDSTAT:  rdMux = {statusWord, cmdReg};
      IDX_CLASS:    rdMux = {CLASS_CODE, REVISION};
      IDX_MISC:     rdMux = {16'd0, latTimer, 8'd0};
      IDX_BAR0:     rdMux = barRead[0];
      IDX_BAR0 + 6'd1: rdMux = barRead[1];
      IDX_BAR0 + 6'd2: rdMux = barRead[2];
      IDX_SUBSYS:   rdMux = {SUB_ID, SUB_VEN_ID};
      IDX_CAP:      rdMux = {24'd0, CAP_PTR};
      IDX_INTR:     rdMux = {16'd0, INT_PIN, intLine};
      default:      rdMux = 32'd0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgRdValid <= 1'b0;
      cfgRdData  <= '0;
    end else begin
      cfgRdValid <= strobe.rdEn;
      cfgRdData  <= strobe.rdEn ? rdMux : 32'd0;
    end
  end
endmodule

// File: rtl/cfgspace_top.sv
module cfgspace_top
  import cfgspace_pkg::*;
#(
  parameter logic [15:0]           VENDOR_ID  = 16'h1A2B,
  parameter logic [15:0]           DEVICE_ID  = 16'h3C4D,
  parameter logic [7:0]            REVISION   = 8'h02,
  parameter logic [23:0]           CLASS_CODE = 24'h118000,
  parameter logic [15:0]           SUB_VEN_ID = 16'h7A8B,
  parameter logic [15:0]           SUB_ID     = 16'h5E6F,
  parameter logic [7:0]            CAP_PTR    = 8'h40,
  parameter logic [7:0]            INT_PIN    = 8'h01,
  parameter logic [NUM_BARS-1:0]   BAR_USED   = 3'b111,
  parameter logic [NUM_BARS-1:0]   BAR_IS_IO  = 3'b010,
  parameter logic [5*NUM_BARS-1:0] BAR_LOG2   = {5'd31, 5'd5, 5'd12}
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        cfgValid,
  input  logic        cfgWrite,
  input  logic [5:0]  cfgRegNum,
  input  logic [3:0]  cfgByteEn,
  input  logic [31:0] cfgWrData,
  output logic [31:0] cfgRdData,
  output logic        cfgRdValid,
  input  logic        parityErrEvt,
  input  logic        targetAbortEvt,
  input  logic [31:0] busAddr,
  input  logic        busAddrValid,
  input  logic        busIsIo,
  output logic [2:0]  barHit
);
  cfgStrobe_t             strobe;
  logic [1:0]             spaceEn;
  logic [NUM_BARS*32-1:0] barBases;

  cfgspace_ctrl #(
    .BAR_USED(BAR_USED), .BAR_IS_IO(BAR_IS_IO), .BAR_LOG2(BAR_LOG2)
  ) u_ctrl (
    .cfgValid(cfgValid), .cfgWrite(cfgWrite), .cfgRegNum(cfgRegNum),
    .cfgByteEn(cfgByteEn), .busAddr(busAddr), .busAddrValid(busAddrValid),
    .busIsIo(busIsIo), .spaceEn(spaceEn), .barBases(barBases),
    .strobe(strobe), .barHit(barHit)
  );

  cfgspace_datapath #(
    .VENDOR_ID(VENDOR_ID), .DEVICE_ID(DEVICE_ID), .REVISION(REVISION),
    .CLASS_CODE(CLASS_CODE), .SUB_VEN_ID(SUB_VEN_ID), .SUB_ID(SUB_ID),
    .CAP_PTR(CAP_PTR), .INT_PIN(INT_PIN), .BAR_USED(BAR_USED),
    .BAR_IS_IO(BAR_IS_IO), .BAR_LOG2(BAR_LOG2)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .cfgRegNum(cfgRegNum),
    .cfgByteEn(cfgByteEn), .cfgWrData(cfgWrData), .parityErrEvt(parityErrEvt),
    .targetAbortEvt(targetAbortEvt), .spaceEn(spaceEn), .barBases(barBases),
    .cfgRdData(cfgRdData), .cfgRdValid(cfgRdValid)
  );
endmodule

// File: rtl/cfgspace_chk.sv
module cfgspace_chk (
  input logic        clk,
  input logic        rstN,
  input logic        cfgValid,
  input logic        cfgWrite,
  input logic [5:0]  cfgRegNum,
  input logic        cfgRdValid,
  input logic [31:0] cfgRdData,
  input logic        busAddrValid,
  input logic        busIsIo,
  input logic [1:0]  spaceEn,
  input logic [2:0]  barHit
);
  // R3
  rd_valid_follows_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cfgValid && !cfgWrite) |=> cfgRdValid);

  // R3
  rd_valid_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    cfgRdValid |-> $past(cfgValid && !cfgWrite));

  // R3
  rd_data_idle_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    !cfgRdValid |-> (cfgRdData == 32'd0));

  // R2
  beyond_header_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cfgRdValid && ($past(cfgRegNum) >= 6'd16)) |-> (cfgRdData == 32'd0));

  // R10
  hit_needs_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    (|barHit) |-> busAddrValid);

  // R10
  hit_needs_enable_chk: assert property (@(posedge clk) disable iff (!rstN)
    (|barHit) |-> (busIsIo ? spaceEn[0] : spaceEn[1]));
endmodule

bind cfgspace_top cfgspace_chk u_chk (
  .clk(clk), .rstN(rstN), .cfgValid(cfgValid), .cfgWrite(cfgWrite),
  .cfgRegNum(cfgRegNum), .cfgRdValid(cfgRdValid), .cfgRdData(cfgRdData),
  .busAddrValid(busAddrValid), .busIsIo(busIsIo), .spaceEn(spaceEn),
  .barHit(barHit)
);

// File: tb/cfgspace_top_test.sv
module cfgspace_top_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgValid = 1'b0, cfgWrite = 1'b0;
  logic [5:0]  cfgRegNum = '0;
  logic [3:0]  cfgByteEn = '0;
  logic [31:0] cfgWrData = '0;
  logic [31:0] cfgRdData;
  logic        cfgRdValid;
  logic        parityErrEvt = 1'b0, targetAbortEvt = 1'b0;
  logic [31:0] busAddr = '0;
  logic        busAddrValid = 1'b0, busIsIo = 1'b0;
  logic [2:0]  barHit;

  int    nChecks = 0;
  int    nFails  = 0;
  string curReq  = "R9";
  bit    started = 1'b0;

  always #5 clk = ~clk;

  cfgspace_top uut (.*);

  // ---------------- behavioural reference model ----------------
  int          sizeLog2 [3] = '{12, 5, 31};
  bit          isIo     [3] = '{1'b0, 1'b1, 1'b0};
  logic [15:0] mCmd;
  bit          mPerr, mTab;
  logic [7:0]  mLat, mInt;
  logic [31:0] mBar [3];
  bit          expValid;
  logic [31:0] expData;

  function automatic logic [31:0] mMask(int k);
    return 32'hFFFF_FFFF << sizeLog2[k];
  endfunction

  function automatic logic [31:0] mRead(logic [5:0] idx);
    case (idx)
      0:  return 32'h3C4D_1A2B;
      1:  return {mPerr, 3'b000, mTab, 11'd0, mCmd};
      2:  return 32'h1180_0002;
      3:  return {16'd0, mLat, 8'd0};
      4, 5, 6: return mBar[idx-4] | {31'd0, isIo[idx-4]};
      11: return 32'h5E6F_7A8B;
      13: return 32'h0000_0040;
      15: return {16'd0, 8'h01, mInt};
      default: return 32'd0;
    endcase
  endfunction

  function automatic logic [2:0] mHits();
    logic [2:0] h = '0;
    for (int k = 0; k < 3; k++) begin
      bit en = isIo[k] ? mCmd[0] : mCmd[1];
      if (busAddrValid && (busIsIo == isIo[k]) && en &&
          (((busAddr ^ mBar[k]) >> sizeLog2[k]) == 0))
        h[k] = 1'b1;
    end
    return h;
  endfunction

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mCmd = 0; mPerr = 0; mTab = 0; mLat = 0; mInt = 0;
      for (int k = 0; k < 3; k++) mBar[k] = 0;
      expValid = 0; expData = 0;
    end else begin
      expValid = cfgValid && !cfgWrite;
      expData  = expValid ? mRead(cfgRegNum) : 32'd0;
      if (cfgValid && cfgWrite) begin
        case (cfgRegNum)
          1: begin
            if (cfgByteEn[0]) mCmd[7:0] = cfgWrData[7:0] & 8'b0100_0111;
            if (cfgByteEn[1]) mCmd[8]   = cfgWrData[8];
            if (cfgByteEn[3] && cfgWrData[31]) mPerr = 0;
            if (cfgByteEn[3] && cfgWrData[27]) mTab  = 0;
          end
          3:  if (cfgByteEn[1]) mLat = cfgWrData[15:8];
          15: if (cfgByteEn[0]) mInt = cfgWrData[7:0];
          4, 5, 6: begin
            for (int b = 0; b < 4; b++)
              if (cfgByteEn[b]) mBar[cfgRegNum-4][8*b +: 8] = cfgWrData[8*b +: 8];
            mBar[cfgRegNum-4] = mBar[cfgRegNum-4] & mMask(cfgRegNum-4);
          end
          default: ;
        endcase
      end
      if (parityErrEvt)   mPerr = 1;
      if (targetAbortEvt) mTab  = 1;
    end
  end

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (started && rstN) begin
      nChecks += 3;
      if (cfgRdValid !== expValid) begin
        nFails++; $display("FAIL %s model rdValid act=%0b exp=%0b", curReq, cfgRdValid, expValid);
      end
      if (cfgRdData !== expData) begin
        nFails++; $display("FAIL %s model rdData act=%h exp=%h", curReq, cfgRdData, expData);
      end
      if (barHit !== mHits()) begin
        nFails++; $display("FAIL %s model barHit act=%b exp=%b", curReq, barHit, mHits());
      end
    end
  end

  // ---------------- directed stimulus ----------------
  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic cfgWr(logic [5:0] idx, logic [3:0] be, logic [31:0] d);
    @(posedge clk); #1;
    cfgValid = 1; cfgWrite = 1; cfgRegNum = idx; cfgByteEn = be; cfgWrData = d;
    @(posedge clk); #1;
    cfgValid = 0; cfgWrite = 0;
  endtask

  task automatic expectRd(logic [5:0] idx, logic [31:0] exp, string req);
    @(posedge clk); #1;
    cfgValid = 1; cfgWrite = 0; cfgRegNum = idx;
    @(posedge clk); #1;
    cfgValid = 0;
    @(negedge clk);
    chk(cfgRdValid === 1'b1 && cfgRdData === exp, req, cfgRdData, exp);
  endtask

  task automatic probe(logic [31:0] a, bit io, logic [2:0] exp, string req);
    @(posedge clk); #1;
    busAddr = a; busIsIo = io; busAddrValid = 1;
    @(negedge clk);
    chk(barHit === exp, req, {29'd0, barHit}, {29'd0, exp});
    @(posedge clk); #1;
    busAddrValid = 0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1; started = 1;

    curReq = "R9";
    expectRd(1, 32'h0, "R9 cmd/status after reset");
    expectRd(3, 32'h0, "R9 latency after reset");
    expectRd(15, 32'h0000_0100, "R9 int line after reset");
    expectRd(4, 32'h0, "R9 bar0 after reset");
    expectRd(5, 32'h1, "R9 bar1 after reset");

    curReq = "R1";
    expectRd(0, 32'h3C4D_1A2B, "R1 ids");
    expectRd(2, 32'h1180_0002, "R1 class/rev");
    expectRd(11, 32'h5E6F_7A8B, "R1 subsystem");

    curReq = "R11";
    expectRd(13, 32'h0000_0040, "R11 cap pointer");

    curReq = "R2";
    foreach (sizeLog2[k]) begin end
    expectRd(7, 0, "R2 idx7"); expectRd(8, 0, "R2 idx8"); expectRd(9, 0, "R2 idx9");
    expectRd(10, 0, "R2 idx10"); expectRd(12, 0, "R2 idx12"); expectRd(14, 0, "R2 idx14");
    for (int i = 16; i < 64; i++) expectRd(6'(i), 0, "R2 beyond header");

    curReq = "R6";
    cfgWr(0, 4'hF, 32'hFFFF_FFFF);  cfgWr(2, 4'hF, 32'hFFFF_FFFF);
    cfgWr(11, 4'hF, 32'hFFFF_FFFF); cfgWr(13, 4'hF, 32'hFFFF_FFFF);
    cfgWr(20, 4'hF, 32'hFFFF_FFFF);
    expectRd(0, 32'h3C4D_1A2B, "R6 ids");
    expectRd(2, 32'h1180_0002, "R6 class");
    expectRd(11, 32'h5E6F_7A8B, "R6 subsystem");
    expectRd(13, 32'h0000_0040, "R6 cap");
    expectRd(20, 32'h0, "R2 write beyond header");

    curReq = "R7";
    cfgWr(1, 4'b0011, 32'h0000_FFFF);
    expectRd(1, 32'h0000_0147, "R7 command mask");

    curReq = "R4";
    cfgWr(4, 4'hF, 32'hFFFF_FFFF); cfgWr(5, 4'hF, 32'hFFFF_FFFF); cfgWr(6, 4'hF, 32'hFFFF_FFFF);
    expectRd(4, 32'hFFFF_F000, "R4 bar0 4KB mem");
    expectRd(5, 32'hFFFF_FFE1, "R4 bar1 32B io");
    expectRd(6, 32'h8000_0000, "R4 bar2 2GB mem");

    curReq = "R5";
    cfgWr(4, 4'b0100, 32'h00AB_0000);
    expectRd(4, 32'hFFAB_F000, "R5 bar byte lane");
    cfgWr(15, 4'b0010, 32'h0000_0055);
    expectRd(15, 32'h0000_0100, "R5 disabled lane ignored");

    curReq = "R12";
    cfgWr(3, 4'hF, 32'hFFFF_FFFF);
    expectRd(3, 32'h0000_FF00, "R12 latency");
    cfgWr(15, 4'hF, 32'hFFFF_FFFF);
    expectRd(15, 32'h0000_01FF, "R12 int line");

    curReq = "R8";
    @(posedge clk); #1 parityErrEvt = 1;
    @(posedge clk); #1 parityErrEvt = 0;
    expectRd(1, 32'h8000_0147, "R8 parity sets");
    @(posedge clk); #1 targetAbortEvt = 1;
    @(posedge clk); #1 targetAbortEvt = 0;
    expectRd(1, 32'h8800_0147, "R8 abort sets");
    cfgWr(1, 4'b0111, 32'h0800_0147);
    expectRd(1, 32'h8800_0147, "R8 no clear without lane 3");
    cfgWr(1, 4'b1000, 32'h8000_0000);
    expectRd(1, 32'h0800_0147, "R8 w1c parity");
    @(posedge clk); #1;
    cfgValid = 1; cfgWrite = 1; cfgRegNum = 1; cfgByteEn = 4'b1000;
    cfgWrData = 32'h0800_0000; targetAbortEvt = 1;
    @(posedge clk); #1;
    cfgValid = 0; cfgWrite = 0; targetAbortEvt = 0;
    expectRd(1, 32'h0800_0147, "R8 set beats clear");

    curReq = "R10";
    cfgWr(4, 4'hF, 32'h1234_5000);
    cfgWr(5, 4'hF, 32'h0000_C020);
    cfgWr(6, 4'hF, 32'h8000_0000);
    probe(32'h1234_5ABC, 0, 3'b001, "R10 mem inside bar0");
    probe(32'h1234_6000, 0, 3'b000, "R10 mem just outside bar0");
    probe(32'h0000_C03F, 1, 3'b010, "R10 io bar1");
    probe(32'h0000_C03F, 0, 3'b000, "R10 wrong space type");
    probe(32'h9000_0000, 0, 3'b100, "R10 2GB bar2");
    cfgWr(1, 4'b0001, 32'h0000_0001);
    probe(32'h1234_5ABC, 0, 3'b000, "R10 mem disabled");
    probe(32'h0000_C020, 1, 3'b010, "R10 io still enabled");

    curReq = "R9";
    @(posedge clk); #1 rstN = 0;
    repeat (2) @(posedge clk);
    #1 rstN = 1;
    expectRd(1, 32'h0, "R9 cmd/status after mid reset");
    expectRd(4, 32'h0, "R9 bar0 base cleared");
    expectRd(15, 32'h0000_0100, "R9 int line cleared");
    probe(32'h0000_0000, 0, 3'b000, "R10 no hit after reset");

    repeat (2) @(posedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    #2_000_000;
    nFails++;
    $display("FAIL watchdog expired in %s act=running exp=done", curReq);
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule